// File: doc/BRIEF.md
# Daisy-Chain Refresh Sequencer Host

This block is the host side of a serial refresh link for a chain of auto-latching LED drivers. It drives one data line and one shift clock into a cascade of `NUM_DEV` drivers. Each driver takes a 224-bit packet. For each frame the block streams every packet most-significant bit first. The packet for the device farthest down the chain goes out first and the packet for the nearest device goes out last.

After the last data bit the block parks the shift clock low. The pause is long enough for every driver in the chain to detect the idle clock and latch its packet. The block then waits a settling interval. Finally it sends padding clocks with the data line held low. The drivers use the shift clock as their PWM grayscale clock, so the padding count is chosen to make data clocks plus padding clocks equal exactly one PWM period of `PERIOD_CLKS` clocks (65536 by default). The next frame's data clocks then continue that PWM count without a gap.

Packet bits come from an external frame buffer through a combinational read port:
- The block presents a device index and a bit index.
- The frame buffer returns the addressed bit in the same cycle.

A start/busy/done handshake lets the frame source know when the buffer may be rewritten. Composing packet fields and building frame content are the frame source's job, not this block's.

Top module: `chain_refresh_host`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `sck_o`, `sdo_o`, `busy_o` and `done_o` are all 0. Reset acts asynchronously, including in the middle of a frame.
- R2: A high `start_i` sampled while `busy_o` is 0 starts a frame. `busy_o` is 1 from the next cycle until the frame ends.
- R3: A frame sends `NUM_DEV*PKT_BITS` data clocks. The bit on `sdo_o` at the k-th rising `sck_o` edge (k from 0) is `fb_data_i` for device `NUM_DEV-1-k/PKT_BITS` and bit `PKT_BITS-1-k%PKT_BITS`. In the first cycle of a frame, `fb_dev_o`=`NUM_DEV-1` and `fb_bit_o`=`PKT_BITS-1`.
- R4: `sdo_o` changes only while `sck_o` is low; it never changes during a high phase of `sck_o`.
- R5: After the last data clock, `sck_o` stays low. The gap from the last data rising edge to the next rising edge is at least `(LATCH_PERIODS+1)` serial periods plus `SETTLE_CYC` system cycles. One serial period is `2*HALF_CYC` system cycles.
- R6: After the settling wait, the block sends `PERIOD_CLKS-NUM_DEV*PKT_BITS` padding clocks, all with `sdo_o` low.
- R7: Each frame produces exactly `PERIOD_CLKS` rising edges on `sck_o`.
- R8: `done_o` is a single-cycle pulse in the first cycle with `busy_o` low after a frame. A `start_i` seen in that cycle starts the next frame at once.
- R9: `start_i` pulses while `busy_o` is 1 are ignored. The frame keeps its clock count, and no second frame follows.
- R10: Whenever no data bit is being sent (latch wait, settle wait, idle), `sdo_o` is 0. When idle, `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send one frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| fb_dev_o | output | DEV_W | Frame buffer device index |
| fb_bit_o | output | BIT_W | Frame buffer bit index within packet |
| fb_data_i | input | 1 | Addressed packet bit, valid in the same cycle |
| sck_o | output | 1 | Shift clock to the chain |
| sdo_o | output | 1 | Serial data to the chain |

## Verification
The hardest situation to reach from the ports is a frame boundary under continuous demand. In that case `start_i` is already high when `done_o` pulses, so the next frame's data must begin without the PWM count losing or gaining a clock. The bench holds `start_i` high across a frame end. It checks that `busy_o` returns at once and that the following frame still has exactly `PERIOD_CLKS` rising edges with correct data. The latch gap is only visible as a timing interval, so the bench timestamps the last data rising edge and the first padding rising edge and checks the distance between them. It also pulses `start_i` mid-frame and pulls reset mid-frame to reach the ignore and recovery paths.

// File: rtl/crh_pkg.sv
package crh_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DATA   = 3'd1,
    PH_LATCH  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_PAD    = 3'd4
  } phase_e;
endpackage

// File: rtl/crh_sck_gen.sv
module crh_sck_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DIV_W-1:0] div_q;
  logic             sck_q;
  logic             wrap;

  assign wrap = (div_q == DIV_W'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // high-to-low transition happens at the coming edge
  assign fall_o = run_i & wrap & sck_q;
  assign sck_o  = sck_q;
endmodule

// File: rtl/crh_bit_cursor.sv
module crh_bit_cursor #(
  parameter int NUM_DEV  = 256,
  parameter int PKT_BITS = 224,
  parameter int DEV_W    = 8,
  parameter int BIT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [DEV_W-1:0] dev_o,
  output logic [BIT_W-1:0] bit_o
);
  logic [DEV_W-1:0] dev_q;
  logic [BIT_W-1:0] bit_q;

  // farthest device first, MSB first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      dev_q <= DEV_W'(NUM_DEV - 1);
      bit_q <= BIT_W'(PKT_BITS - 1);
    end else if (step_i) begin
      if (bit_q == '0) begin
        bit_q <= BIT_W'(PKT_BITS - 1);
        if (dev_q != '0) dev_q <= dev_q - 1'b1;
      end else begin
        bit_q <= bit_q - 1'b1;
      end
    end
  end

  assign dev_o = dev_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/crh_wait_timer.sv
module crh_wait_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/crh_seq.sv
module crh_seq
  import crh_pkg::*;
#(
  parameter int NUM_DEV     = 256,
  parameter int PKT_BITS    = 224,
  parameter int PERIOD_CLKS = 65536,
  parameter int LATCH_CYC   = 80,
  parameter int SETTLE_CYC  = 140,
  parameter int TMR_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fall_i,
  input  logic             tmr_zero_i,
  output phase_e           phase_o,
  output logic             run_o,
  output logic             cur_load_o,
  output logic             cur_step_o,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int DATA_CLKS = NUM_DEV * PKT_BITS;
  localparam int PAD_CLKS  = PERIOD_CLKS - DATA_CLKS;
  localparam int PAD_LAST  = (PAD_CLKS > 0) ? PAD_CLKS - 1 : 0;
  localparam int CNT_W     = $clog2(PERIOD_CLKS + 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    cur_load_o = 1'b0;
    cur_step_o = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d    = PH_DATA;
          cnt_d      = '0;
          cur_load_o = 1'b1;
        end
      end
      PH_DATA: begin
        if (fall_i) begin
          if (cnt_q == CNT_W'(DATA_CLKS - 1)) begin
            state_d    = PH_LATCH;
            cnt_d      = '0;
            tmr_load_o = 1'b1;
            tmr_val_o  = TMR_W'(LATCH_CYC);
          end else begin
            cnt_d      = cnt_q + 1'b1;
            cur_step_o = 1'b1;
          end
        end
      end
      PH_LATCH: begin
        if (tmr_zero_i) begin
          state_d    = PH_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TMR_W'(SETTLE_CYC);
        end
      end
      PH_SETTLE: begin
        if (tmr_zero_i) begin
          cnt_d = '0;
          if (PAD_CLKS > 0) begin
            state_d = PH_PAD;
          end else begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_PAD: begin
        if (fall_i) begin
          if (cnt_q == CNT_W'(PAD_LAST)) begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = state_q;
  assign run_o   = (state_q == PH_DATA) || (state_q == PH_PAD);
  assign busy_o  = (state_q != PH_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/chain_refresh_host.sv
module chain_refresh_host
  import crh_pkg::*;
#(
  parameter int NUM_DEV       = 256,
  parameter int PKT_BITS      = 224,
  parameter int PERIOD_CLKS   = 65536,
  parameter int HALF_CYC      = 4,
  parameter int LATCH_PERIODS = 10,
  parameter int SETTLE_CYC    = 140,
  localparam int DEV_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BIT_W        = (PKT_BITS > 1) ? $clog2(PKT_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DEV_W-1:0] fb_dev_o,
  output logic [BIT_W-1:0] fb_bit_o,
  input  logic             fb_data_i,
  output logic             sck_o,
  output logic             sdo_o
);
  localparam int LATCH_CYC = LATCH_PERIODS * 2 * HALF_CYC;
  localparam int TMR_MAX   = (LATCH_CYC > SETTLE_CYC) ? LATCH_CYC : SETTLE_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);

  phase_e           phase;
  logic             run, fall;
  logic             cur_load, cur_step;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  crh_sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  crh_bit_cursor #(
    .NUM_DEV (NUM_DEV),
    .PKT_BITS(PKT_BITS),
    .DEV_W   (DEV_W),
    .BIT_W   (BIT_W)
  ) u_cur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cur_load),
    .step_i (cur_step),
    .dev_o  (fb_dev_o),
    .bit_o  (fb_bit_o)
  );

  crh_wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  crh_seq #(
    .NUM_DEV    (NUM_DEV),
    .PKT_BITS   (PKT_BITS),
    .PERIOD_CLKS(PERIOD_CLKS),
    .LATCH_CYC  (LATCH_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .TMR_W      (TMR_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .fall_i     (fall),
    .tmr_zero_i (tmr_zero),
    .phase_o    (phase),
    .run_o      (run),
    .cur_load_o (cur_load),
    .cur_step_o (cur_step),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // cursor advances on the falling-edge cycle, so data moves with sck low
  assign sdo_o = (phase == PH_DATA) & fb_data_i;
endmodule

// File: rtl/crh_checker.sv
module crh_checker
  import crh_pkg::*;
#(
  parameter int NUM_DEV     = 256,
  parameter int PERIOD_CLKS = 65536,
  parameter int DEV_W       = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [DEV_W-1:0] fb_dev_o,
  input logic             sck_o,
  input logic             sdo_o,
  input phase_e           phase_i
);
  localparam int RC_W = $clog2(PERIOD_CLKS + 1) + 1;

  logic            sck_prev;
  logic [RC_W-1:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_prev <= sck_o;
      if (!busy_o)                rise_cnt <= '0;
      else if (sck_o && !sck_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
  AST_DEV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(fb_dev_o) < NUM_DEV)); // R3
  AST_SDO_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> (sdo_o == $past(sdo_o))); // R4
  AST_LATCH_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_LATCH || phase_i == PH_SETTLE) |-> !sck_o); // R5
  AST_PAD_SDO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_PAD) |-> !sdo_o); // R6
  AST_PERIOD_CLKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rise_cnt == RC_W'(PERIOD_CLKS))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !sdo_o)); // R10
endmodule

bind chain_refresh_host crh_checker #(
  .NUM_DEV    (NUM_DEV),
  .PERIOD_CLKS(PERIOD_CLKS),
  .DEV_W      (DEV_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fb_dev_o (fb_dev_o),
  .sck_o    (sck_o),
  .sdo_o    (sdo_o),
  .phase_i  (phase)
);

// File: tb/chain_refresh_host_tb.sv
module chain_refresh_host_tb;
  localparam int NUM_DEV       = 3;
  localparam int PKT_BITS      = 224;
  localparam int PERIOD_CLKS   = 1024;
  localparam int HALF_CYC      = 2;
  localparam int LATCH_PERIODS = 8;
  localparam int SETTLE_CYC    = 20;
  localparam int DEV_W         = $clog2(NUM_DEV);
  localparam int BIT_W         = $clog2(PKT_BITS);
  localparam int DATA_CLKS     = NUM_DEV * PKT_BITS;
  localparam int MIN_GAP       = (LATCH_PERIODS + 1) * 2 * HALF_CYC + SETTLE_CYC;
  localparam int WD_LIMIT      = 150000;

  typedef struct packed {
    logic [1:0]  mode;   // 0 zeros, 1 ones, 2 hashed, 3 end markers
    logic [15:0] seed;
    logic [7:0]  delay;
    logic        mid_start;
    logic [10:0] exp_rises;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 16'h0000, 8'd3, 1'b0, 11'(PERIOD_CLKS)},
    '{2'd1, 16'h0000, 8'd1, 1'b0, 11'(PERIOD_CLKS)},
    '{2'd3, 16'h0000, 8'd0, 1'b0, 11'(PERIOD_CLKS)},
    '{2'd2, 16'h5a3c, 8'd7, 1'b1, 11'(PERIOD_CLKS)},
    '{2'd2, 16'hc001, 8'd2, 1'b0, 11'(PERIOD_CLKS)}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             busy_o, done_o, sck_o, sdo_o, fb_data_i;
  logic [DEV_W-1:0] fb_dev_o;
  logic [BIT_W-1:0] fb_bit_o;
  logic [1:0]       cur_mode = 2'd0;
  logic [15:0]      cur_seed = 16'h0;

  function automatic logic fb_model(logic [1:0] m, logic [15:0] s, int dev, int b);
    logic [15:0] h;
    case (m)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: begin
        h = s ^ 16'(dev * 977) ^ 16'(b * 131);
        return h[0] ^ h[5] ^ h[9];
      end
      default: return ((dev == NUM_DEV - 1) && (b == PKT_BITS - 1)) || ((dev == 0) && (b == 0));
    endcase
  endfunction

  assign fb_data_i = fb_model(cur_mode, cur_seed, int'(fb_dev_o), int'(fb_bit_o));

  chain_refresh_host #(
    .NUM_DEV      (NUM_DEV),
    .PKT_BITS     (PKT_BITS),
    .PERIOD_CLKS  (PERIOD_CLKS),
    .HALF_CYC     (HALF_CYC),
    .LATCH_PERIODS(LATCH_PERIODS),
    .SETTLE_CYC   (SETTLE_CYC)
  ) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fb_dev_o (fb_dev_o),
    .fb_bit_o (fb_bit_o),
    .fb_data_i(fb_data_i),
    .sck_o    (sck_o),
    .sdo_o    (sdo_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;
  int rises, data_err, pad_ones, hold_viol, quiet_viol, t_last, t_pad;
  int l_rises, l_data_err, l_pad_ones, l_hold_viol, l_quiet_viol, l_gap, l_busy_at_done;
  int done_total = 0;
  logic sck_p = 1'b0, sdo_p = 1'b0;

  function automatic logic exp_stream(int k);
    return fb_model(cur_mode, cur_seed, NUM_DEV - 1 - k / PKT_BITS, PKT_BITS - 1 - k % PKT_BITS);
  endfunction

  task automatic clear_live();
    rises = 0; data_err = 0; pad_ones = 0; hold_viol = 0; quiet_viol = 0; t_last = 0; t_pad = 0;
  endtask

  initial clear_live();

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) wd_hit = 1'b1;
    if (!rst_ni) begin
      clear_live();
      sck_p = 1'b0;
      sdo_p = 1'b0;
    end else begin
      if (sck_o && !sck_p) begin
        if (rises < DATA_CLKS) begin
          if (sdo_o !== exp_stream(rises)) data_err++;
          if (rises == DATA_CLKS - 1) t_last = cyc;
        end else begin
          if (sdo_o) pad_ones++;
          if (rises == DATA_CLKS) t_pad = cyc;
        end
        rises++;
      end
      if (sck_o && sck_p && (sdo_o !== sdo_p)) hold_viol++;
      if (busy_o && rises >= DATA_CLKS && !sck_o && sdo_o) quiet_viol++;
      if (done_o) begin
        l_rises = rises; l_data_err = data_err; l_pad_ones = pad_ones;
        l_hold_viol = hold_viol; l_quiet_viol = quiet_viol; l_gap = t_pad - t_last;
        l_busy_at_done = int'(busy_o);
        done_total++;
        clear_live();
      end
      sck_p = sck_o;
      sdo_p = sdo_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  task automatic wait_done(int target, bit mid);
    int it = 0;
    while (done_total < target && !wd_hit) begin
      if (mid && it == 500) start_i = 1'b1;
      if (mid && it == 501) start_i = 1'b0;
      step();
      it++;
    end
    start_i = 1'b0;
  endtask

  task automatic check_frame(string name, int exp_rises);
    chk_eq({name, " R7 rising edges per frame"}, l_rises, exp_rises);
    chk_eq({name, " R3 data bit mismatches"}, l_data_err, 0);
    chk_eq({name, " R6 padding ones"}, l_pad_ones, 0);
    chk_eq({name, " R4 sdo change in high phase"}, l_hold_viol, 0);
    chk_eq({name, " R10 sdo high outside data"}, l_quiet_viol, 0);
    chk_ge({name, " R5 latch gap cycles"}, l_gap, MIN_GAP);
    chk_eq({name, " R8 busy low with done"}, l_busy_at_done, 0);
  endtask

  task automatic run_vec(vec_t v);
    int tgt;
    cur_mode = v.mode;
    cur_seed = v.seed;
    repeat (int'(v.delay)) step();
    tgt = done_total + 1;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk_eq("R2 busy after start", int'(busy_o), 1);
    chk_eq("R3 first device index", int'(fb_dev_o), NUM_DEV - 1);
    chk_eq("R3 first bit index", int'(fb_bit_o), PKT_BITS - 1);
    wait_done(tgt, v.mid_start);
    check_frame("vec", int'(v.exp_rises));
    if (v.mid_start) begin
      repeat (40) step();
      chk_eq("R9 no extra frame busy", int'(busy_o), 0);
      chk_eq("R9 no extra frame clocks", rises, 0);
      chk_eq("R9 single done", done_total, tgt);
    end
  endtask

  initial begin
    int tgt;
    repeat (3) step();
    chk_eq("R1 sck in reset", int'(sck_o), 0);
    chk_eq("R1 sdo in reset", int'(sdo_o), 0);
    chk_eq("R1 busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (2) step();
    chk_eq("R1 busy after reset", int'(busy_o), 0);
    chk_eq("R1 done after reset", int'(done_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      if (!wd_hit) run_vec(VEC[i]);
    end

    // back-to-back frames with start held high
    if (!wd_hit) begin
      cur_mode = 2'd1;
      tgt = done_total + 1;
      start_i = 1'b1;
      while (done_total < tgt && !wd_hit) step();
      step();
      chk_eq("R8 next frame starts at done", int'(busy_o), 1);
      start_i = 1'b0;
      wait_done(tgt + 1, 1'b0);
      check_frame("b2b", PERIOD_CLKS);
    end

    // reset in the middle of a frame
    if (!wd_hit) begin
      cur_mode = 2'd2;
      cur_seed = 16'h1234;
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      repeat (300) step();
      rst_ni = 1'b0;
      #1;
      chk_eq("R1 mid-frame reset busy", int'(busy_o), 0);
      chk_eq("R1 mid-frame reset sck", int'(sck_o), 0);
      chk_eq("R1 mid-frame reset sdo", int'(sdo_o), 0);
      step();
      rst_ni = 1'b1;
      step();
      run_vec(VEC[4]);
    end

    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule